// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block collects five external interrupt pins and turns their edges into sticky request flags for a small CPU. Two of the lines respond only to a falling edge. The other three lines each have a 2-bit edge code that software sets. The code picks no detection, the falling edge, the rising edge or both edges. Every pin first passes through a synchronizer. An edge is then found by comparing the synchronized level with its level one clock earlier. A detected edge sets that line's flag, and the flag stays set until software writes a 0 to it.

A single global enable gates the interrupt request to the CPU. The request is high while the enable is on and at least one flag is pending. Accepting an interrupt (the acknowledge strobe) turns the enable off. Only a return-from-interrupt strobe turns it back on. Software reaches the flags and the edge codes through a narrow register bus: 2-bit address, 4-bit data, one write strobe and combinational read data. The pins are assumed to idle high. The synchronizer therefore resets to 1, so releasing reset with pins high produces no edge.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset all five flags, the global enable and `irq_req` are 0, and every edge code is 00, so the programmable lines detect nothing.
- R2: A pin change passes two synchronizer flops and one history flop. The flag is still 0 after the second rising clock edge that follows the change, and it reads 1 after the third.
- R3: Lines 0 and 1 set their flags on a falling edge only. A rising edge on these lines leaves the flags unchanged.
- R4: Each of lines 2, 3 and 4 sets its flag according to its 2-bit code: 00 none, 01 falling, 10 rising, 11 both edges.
- R5: The edge codes are write-only. Address 2 holds line 2 in bits 1:0 and line 3 in bits 3:2. Address 3 holds line 4 in bits 1:0 and ignores bits 3:2. Reads at addresses 2 and 3 return 0.
- R6: A read at address 0 returns flag 0 in bit 0, flag 1 in bit 1 and the global enable in bit 2, with bit 3 at 0. A read at address 1 returns the flags of lines 2, 3 and 4 in bits 0, 1 and 2, with bit 3 at 0.
- R7: Writing 0 to a flag bit at address 0 or 1 clears that flag on the next clock. Writing 1 leaves the flag as it was.
- R8: If a detected edge and a clearing write on the same line fall in the same clock, the flag is 1 afterwards.
- R9: `irq_req` is 1 exactly when the global enable is 1 and at least one flag is 1.
- R10: `irq_ack` clears the global enable on the next clock and `irq_rti` sets it on the next clock. When both are high in the same clock, the enable ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 5 | External interrupt pins, line 0 in bit 0 |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Combinational read data for `bus_addr` |
| irq_ack | input | 1 | CPU has accepted an interrupt |
| irq_rti | input | 1 | CPU returns from interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of events can fall in the same clock, and each pair is tested.

The first pair is a detected pin edge and a software write that clears the same flag. The bench lines them up by changing the pin and then counting two clock edges. It drives the clearing write in the following cycle, so the write is sampled on the same edge that records the detection. The flag must read 1 afterwards, and a later write with no edge must still clear it.

The second pair is an acknowledge and a return-from-interrupt strobe raised together. The enable bit read at address 0 and `irq_req` must both show the enable off.

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int N_FIXED     = 2,
  parameter int N_PROG      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] pin_in,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       irq_ack,
  input  logic       irq_rti,
  output logic       irq_req
);
  localparam int N_LINES = N_FIXED + N_PROG;

  logic [N_LINES-1:0] sync_q [SYNC_STAGES];
  logic [N_LINES-1:0] hist_q, cur, rise, fall, det, clr, flag_q;
  logic [3:0] code_a_q;
  logic [1:0] code_b_q;
  logic [2*N_PROG-1:0] codes;
  logic gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
      hist_q <= '1;
    end else begin
      sync_q[0] <= pin_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      hist_q <= cur;
    end
  end

  assign cur   = sync_q[SYNC_STAGES-1];
  assign rise  = cur & ~hist_q;
  assign fall  = ~cur & hist_q;
  assign codes = {code_b_q, code_a_q};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_det
      if (g < N_FIXED) begin : g_fixed
        assign det[g] = fall[g];
      end else begin : g_prog
        assign det[g] = (codes[2*(g-N_FIXED)]   & fall[g]) |
                        (codes[2*(g-N_FIXED)+1] & rise[g]);
      end
    end
  endgenerate

  always_comb begin
    clr = '0;
    if (bus_we && bus_addr == 2'd0) clr[N_FIXED-1:0] = ~bus_wdata[N_FIXED-1:0];
    if (bus_we && bus_addr == 2'd1) clr[N_LINES-1:N_FIXED] = ~bus_wdata[N_PROG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      code_a_q <= '0;
      code_b_q <= '0;
      gen_q    <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | det;
      if (bus_we && bus_addr == 2'd2) code_a_q <= bus_wdata;
      if (bus_we && bus_addr == 2'd3) code_b_q <= bus_wdata[1:0];
      if (irq_ack)      gen_q <= 1'b0;
      else if (irq_rti) gen_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {1'b0, gen_q, flag_q[1:0]};
      2'd1:    bus_rdata = {1'b0, flag_q[4:2]};
      default: bus_rdata = 4'd0;
    endcase
  end

  assign irq_req = gen_q & (|flag_q);

  generate
    for (g = 0; g < N_LINES; g++) begin : g_chk
      p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        det[g] |=> flag_q[g]);
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[g] && !clr[g] |=> flag_q[g]);
      p_clear_wins_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr[g] && !det[g] |=> !flag_q[g]);
      if (g < N_FIXED) begin : g_fx
        p_fixed_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
          !flag_q[g] && cur[g] && !hist_q[g] |=> !flag_q[g]);
      end
    end
  endgenerate

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gen_q);
  p_rti_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rti && !irq_ack |=> gen_q);
  p_gen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_rti && !irq_ack |=> gen_q == $past(gen_q));
  p_none_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    codes[1:0] == 2'b00 && !flag_q[2] |=> !flag_q[2]);
endmodule

// File: tb/ext_irq_edge_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_edge_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pin_in = 5'b11111;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_wdata = 4'd0;
  logic [3:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_rti = 1'b0;
  logic       irq_req;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_rti(irq_rti), .irq_req(irq_req)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [3:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [3:0] d;
    rd(2'd0, d); check("R1 addr0", d, 4'b0000);
    rd(2'd1, d); check("R1 addr1", d, 4'b0000);
    check("R1 irq_req", {3'b0, irq_req}, 4'b0000);
    pin_in[2] = 1'b0; settle();
    rd(2'd1, d); check("R1 codes zero", d, 4'b0000);
    pin_in[2] = 1'b1; settle();
    rd(2'd2, d); check("R5 write-only addr2", d, 4'b0000);
  endtask

  task automatic t_fixed();
    logic [3:0] d;
    pin_in[0] = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(2'd0, d); check("R2 not yet", d, 4'b0000);
    @(posedge clk); @(negedge clk);
    rd(2'd0, d); check("R2 R3 fall line0", d, 4'b0001);
    pin_in[0] = 1'b1; pin_in[1] = 1'b0; settle();
    rd(2'd0, d); check("R3 fall line1", d, 4'b0011);
    pin_in[1] = 1'b1; settle();
    wr(2'd0, 4'b0010);
    rd(2'd0, d); check("R7 clear line0 only", d, 4'b0010);
    pin_in[0] = 1'b0; settle(); pin_in[0] = 1'b1; settle();
    wr(2'd0, 4'b0001);
    rd(2'd0, d); check("R3 no rise flag / R7", d, 4'b0001);
    wr(2'd0, 4'b0000);
    rd(2'd0, d); check("R7 all clear", d, 4'b0000);
  endtask

  task automatic t_prog();
    logic [3:0] d;
    wr(2'd2, 4'b1001);
    wr(2'd3, 4'b1111);
    pin_in[4:2] = 3'b000; settle();
    rd(2'd1, d); check("R4 R5 falling pass", d, 4'b0101);
    pin_in[4:2] = 3'b111; settle();
    rd(2'd1, d); check("R4 R5 rising pass", d, 4'b0111);
    wr(2'd1, 4'b0000);
    rd(2'd1, d); check("R7 clear prog", d, 4'b0000);
    pin_in[4] = 1'b0; settle();
    rd(2'd1, d); check("R4 both line4 fall", d, 4'b0100);
    wr(2'd1, 4'b0000); pin_in[4] = 1'b1; settle();
    rd(2'd1, d); check("R4 both line4 rise", d, 4'b0100);
    wr(2'd1, 4'b0000);
    wr(2'd2, 4'b0100);
    pin_in[3:2] = 2'b00; settle();
    rd(2'd1, d); check("R4 code00 line2 code01 line3", d, 4'b0010);
    pin_in[3:2] = 2'b11; settle();
    wr(2'd1, 4'b0000);
    rd(2'd3, d); check("R5 write-only addr3", d, 4'b0000);
    rd(2'd1, d); check("R6 addr1 cleared", d, 4'b0000);
  endtask

  task automatic t_enable();
    logic [3:0] d;
    irq_rti = 1'b1; @(posedge clk); @(negedge clk); irq_rti = 1'b0;
    rd(2'd0, d); check("R10 rti sets, R6 bit2", d, 4'b0100);
    check("R9 no flag no req", {3'b0, irq_req}, 4'b0000);
    pin_in[1] = 1'b0; settle(); pin_in[1] = 1'b1;
    check("R9 req raised", {3'b0, irq_req}, 4'b0001);
    irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
    check("R10 ack drops req", {3'b0, irq_req}, 4'b0000);
    irq_ack = 1'b1; irq_rti = 1'b1; @(posedge clk); @(negedge clk);
    irq_ack = 1'b0; irq_rti = 1'b0;
    rd(2'd0, d); check("R10 ack beats rti", d, 4'b0010);
    irq_rti = 1'b1; @(posedge clk); @(negedge clk); irq_rti = 1'b0;
    check("R9 req after rti", {3'b0, irq_req}, 4'b0001);
    settle();
    wr(2'd0, 4'b0000);
    check("R9 req drops on clear", {3'b0, irq_req}, 4'b0000);
    rd(2'd0, d); check("R6 gen kept", d, 4'b0100);
  endtask

  task automatic t_collide();
    logic [3:0] d;
    wr(2'd2, 4'b0011);
    pin_in[2] = 1'b0; settle();
    rd(2'd1, d); check("R8 pre-set", d, 4'b0001);
    pin_in[2] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    wr(2'd1, 4'b0000);
    rd(2'd1, d); check("R8 edge beats clear", d, 4'b0001);
    wr(2'd1, 4'b0000);
    rd(2'd1, d); check("R8 later clear", d, 4'b0000);
    pin_in[2] = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    wr(2'd1, 4'b0000);
    rd(2'd1, d); check("R8 set from clear", d, 4'b0001);
    pin_in[2] = 1'b1; settle();
    wr(2'd1, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_prog();
    t_enable();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule